// File: doc/BRIEF.md
# PHY Error Event Statistics Counters

This block keeps two 8-bit statistics counters for a 100 Mb/s Ethernet physical layer. One counts false-carrier events. The other counts receive-error events. A receive error is scored when an invalid data symbol occurs while the carrier is valid. It is scored at most once per carrier event, and it is not scored when a collision has already been seen in that event. The line decoder upstream presents each condition as a per-cycle strobe. This block only qualifies and accumulates those strobes.

Management logic reads and writes the counters through a simple register port. Each counter sits in the low byte of a 16-bit register. Read data comes back one cycle after the request. A read clears the counter it returns, so software always sees the events since its last read. Neither counter wraps: once a counter reaches FFh it stays there until it is read or written.

Top module: `phy_err_stats`

## Requirements
- R1: Each counter register is 16 bits wide with the counter in bits 7:0. Bits 15:8 always read as 0, and writes to bits 15:8 have no effect.
- R2: After a synchronous active-high reset, both counters are 00h.
- R3: The false-carrier counter increases by exactly one for each clock cycle in which `fc_event` is high.
- R4: Each counter stops at FFh. Further qualifying events leave it at FFh.
- R5: A read of a counter returns its value before the read. The counter is then 00h on the next cycle.
- R6: The receive-error counter increases only in a cycle where both `carrier_valid` and `invalid_symbol` are high.
- R7: A carrier event runs from a rising edge of `carrier_valid` until the signal falls. Within one carrier event, the receive-error counter increases at most once, however many invalid symbols occur.
- R8: A collision seen in a carrier event before, or in the same cycle as, the first invalid symbol blocks the count for that event. A collision that comes after the count was taken does not remove it.
- R9: A write to a mapped address loads `reg_wdata[7:0]` into that counter. A write wins over an event or a read-clear in the same cycle.
- R10: The false-carrier counter is at address D0h and the receive-error counter at D4h. A read of any other address returns 0000h. Read data appears in the cycle after `reg_rd` and holds until the next read.
- R11: A qualifying event in the same cycle as a read of its counter is not lost. The read returns the old value and the counter becomes 01h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fc_event | input | 1 | False-carrier event strobe, one count per high cycle |
| carrier_valid | input | 1 | High while a valid carrier is present |
| invalid_symbol | input | 1 | Invalid data symbol seen this cycle |
| collision | input | 1 | Collision present this cycle |
| reg_addr | input | 8 | Register byte address |
| reg_rd | input | 1 | Read request, clears the addressed counter |
| reg_wr | input | 1 | Write request |
| reg_wdata | input | 16 | Write data, only bits 7:0 are stored |
| reg_rdata | output | 16 | Registered read data |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high together. They also assume the event strobes are clean single-cycle levels that are valid at every clock edge. The stepping and hold properties are gated so that they apply only to cycles with no register access to the counter being checked. The bench changes every input on the falling clock edge. It issues reads and writes as separate one-cycle pulses and never overlaps them. The only deliberate overlap is an event strobe in the same cycle as a read, which exercises the lost-event case.

// File: rtl/phy_err_stats_pkg.sv
package phy_err_stats_pkg;
  localparam int REG_W   = 16;
  localparam int CNT_W   = 8;
  localparam int NUM_CNT = 2;
  localparam int IDX_FC  = 0;
  localparam int IDX_RX  = 1;
endpackage

// File: rtl/sat_clr_counter.sv
module sat_clr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         rd_clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (wr_en)
      cnt <= wr_val;
    else if (rd_clr)
      cnt <= inc ? ONE : '0;
    else if (inc && cnt != MAXV)
      cnt <= cnt + ONE;
  end
endmodule

// File: rtl/rxerr_qualifier.sv
module rxerr_qualifier (
  input  logic clk,
  input  logic rst,
  input  logic carrier_valid,
  input  logic invalid_symbol,
  input  logic collision,
  output logic count_pulse
);
  logic cv_q;
  logic settled_q;
  logic new_carrier;
  logic settled_eff;

  // Per-carrier flag: set once the event is counted or a collision is seen.
  assign new_carrier = carrier_valid & ~cv_q;
  assign settled_eff = settled_q & ~new_carrier;
  assign count_pulse = carrier_valid & invalid_symbol & ~collision & ~settled_eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      cv_q      <= 1'b0;
      settled_q <= 1'b0;
    end else begin
      cv_q      <= carrier_valid;
      settled_q <= carrier_valid & (settled_eff | invalid_symbol | collision);
    end
  end
endmodule

// File: rtl/phy_err_stats.sv
module phy_err_stats
  import phy_err_stats_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] FC_OFFS = 8'hD0,
  parameter logic [ADDR_W-1:0] RX_OFFS = 8'hD4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fc_event,
  input  logic              carrier_valid,
  input  logic              invalid_symbol,
  input  logic              collision,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  logic [NUM_CNT-1:0] sel;
  logic [NUM_CNT-1:0] inc;
  logic [CNT_W-1:0]   cnt_q [NUM_CNT];
  logic [REG_W-1:0]   rd_mux;
  logic               rx_pulse;
  logic               unused_wdata_hi;
  logic [CNT_W-1:0]   fc_cnt_w;
  logic [CNT_W-1:0]   rx_cnt_w;

  assign unused_wdata_hi = ^reg_wdata[REG_W-1:CNT_W];

  assign sel[IDX_FC] = (reg_addr == FC_OFFS);
  assign sel[IDX_RX] = (reg_addr == RX_OFFS);

  rxerr_qualifier u_qual (
    .clk           (clk),
    .rst           (rst),
    .carrier_valid (carrier_valid),
    .invalid_symbol(invalid_symbol),
    .collision     (collision),
    .count_pulse   (rx_pulse)
  );

  assign inc[IDX_FC] = fc_event;
  assign inc[IDX_RX] = rx_pulse;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
      sat_clr_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .inc   (inc[gi]),
        .rd_clr(reg_rd & sel[gi]),
        .wr_en (reg_wr & sel[gi]),
        .wr_val(reg_wdata[CNT_W-1:0]),
        .cnt   (cnt_q[gi])
      );
    end
  endgenerate

  assign fc_cnt_w = cnt_q[IDX_FC];
  assign rx_cnt_w = cnt_q[IDX_RX];

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (sel[i]) rd_mux = {{(REG_W-CNT_W){1'b0}}, cnt_q[i]};
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/phy_err_stats_chk.sv
module phy_err_stats_chk
  import phy_err_stats_pkg::*;
#(
  parameter int              ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] FC_OFFS = 8'hD0,
  parameter logic [ADDR_W-1:0] RX_OFFS = 8'hD4
) (
  input logic              clk,
  input logic              rst,
  input logic              fc_event,
  input logic              carrier_valid,
  input logic              collision,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  reg_rdata,
  input logic [CNT_W-1:0]  fc_cnt,
  input logic [CNT_W-1:0]  rx_cnt
);
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  logic fc_acc, rx_acc, fc_rd, fc_wr, unmapped_rd;
  assign fc_rd  = reg_rd & (reg_addr == FC_OFFS);
  assign fc_wr  = reg_wr & (reg_addr == FC_OFFS);
  assign fc_acc = (reg_rd | reg_wr) & (reg_addr == FC_OFFS);
  assign rx_acc = (reg_rd | reg_wr) & (reg_addr == RX_OFFS);
  assign unmapped_rd = reg_rd & (reg_addr != FC_OFFS) & (reg_addr != RX_OFFS);

  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[REG_W-1:CNT_W] == '0);
  p_reset_clear_r2: assert property (@(posedge clk)
    $past(rst) |-> (fc_cnt == '0 && rx_cnt == '0));
  p_fc_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!fc_acc && fc_cnt != MAXV) |=> fc_cnt == $past(fc_cnt) + {{(CNT_W-1){1'b0}}, $past(fc_event)});
  p_saturate_r4: assert property (@(posedge clk) disable iff (rst)
    (!fc_acc && fc_cnt == MAXV) |=> fc_cnt == MAXV);
  p_read_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (fc_rd && !fc_event) |=> (fc_cnt == '0 && reg_rdata[CNT_W-1:0] == $past(fc_cnt)));
  p_no_carrier_r6: assert property (@(posedge clk) disable iff (rst)
    (!carrier_valid && !rx_acc) |=> $stable(rx_cnt));
  p_collision_block_r8: assert property (@(posedge clk) disable iff (rst)
    (collision && !rx_acc) |=> $stable(rx_cnt));
  p_write_load_r9: assert property (@(posedge clk) disable iff (rst)
    fc_wr |=> fc_cnt == $past(reg_wdata[CNT_W-1:0]));
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    unmapped_rd |=> reg_rdata == '0);
  p_event_kept_r11: assert property (@(posedge clk) disable iff (rst)
    (fc_rd && fc_event) |=> fc_cnt == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

bind phy_err_stats phy_err_stats_chk #(
  .ADDR_W(ADDR_W), .FC_OFFS(FC_OFFS), .RX_OFFS(RX_OFFS)
) u_chk (
  .clk(clk), .rst(rst), .fc_event(fc_event), .carrier_valid(carrier_valid),
  .collision(collision), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fc_cnt(fc_cnt_w), .rx_cnt(rx_cnt_w)
);

// File: tb/sim_phy_err_stats.sv
`timescale 1ns/1ps
module sim_phy_err_stats;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fc_event = 1'b0, carrier_valid = 1'b0, invalid_symbol = 1'b0, collision = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic        reg_rd = 1'b0, reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  int checks = 0, fails = 0;
  logic [15:0] rv;

  localparam logic [7:0] A_FC = 8'hD0, A_RX = 8'hD4;

  always #4 clk = ~clk;

  phy_err_stats u0 (
    .clk(clk), .rst(rst), .fc_event(fc_event), .carrier_valid(carrier_valid),
    .invalid_symbol(invalid_symbol), .collision(collision), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic fc_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fc_event = 1'b1;
    end
    @(negedge clk); fc_event = 1'b0;
  endtask

  // coll: 0 none, 1 before first invalid, 2 same cycle, 3 after invalids
  task automatic carrier(input int n_inv, input int coll);
    @(negedge clk); carrier_valid = 1'b1;
    if (coll == 1) begin collision = 1'b1; @(negedge clk); collision = 1'b0; end
    for (int i = 0; i < n_inv; i++) begin
      invalid_symbol = 1'b1;
      collision = (coll == 2 && i == 0);
      @(negedge clk);
      invalid_symbol = 1'b0; collision = 1'b0;
      @(negedge clk);
    end
    if (coll == 3) begin collision = 1'b1; @(negedge clk); collision = 1'b0; end
    carrier_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R2 reset state
    rd(A_FC, rv); check("R2 fc reset", rv, 16'h0000);
    rd(A_RX, rv); check("R2 rx reset", rv, 16'h0000);
    // R3/R5 sweep of event counts, each read clears for the next
    for (int n = 0; n <= 20; n++) begin
      fc_pulses(n);
      rd(A_FC, rv); check("R3 fc count", rv, 16'(n));
    end
    rd(A_FC, rv); check("R5 cleared", rv, 16'h0000);
    // R4 saturation of false-carrier counter
    fc_pulses(300);
    rd(A_FC, rv); check("R4 fc sticks", rv, 16'h00FF);
    rd(A_FC, rv); check("R5 clear after sat", rv, 16'h0000);
    // R7 one count per carrier for several invalid counts
    for (int k = 0; k <= 5; k++) begin
      carrier(k, 0);
      rd(A_RX, rv); check("R7 once per carrier", rv, (k > 0) ? 16'h1 : 16'h0);
    end
    for (int m = 1; m <= 4; m++) begin
      for (int j = 0; j < m; j++) carrier(3, 0);
      rd(A_RX, rv); check("R7 multi carrier", rv, 16'(m));
    end
    // R6 invalid symbol without carrier
    @(negedge clk); invalid_symbol = 1'b1;
    repeat (4) @(negedge clk);
    invalid_symbol = 1'b0;
    rd(A_RX, rv); check("R6 no carrier", rv, 16'h0000);
    // R8 collision cases
    carrier(2, 1); rd(A_RX, rv); check("R8 collision before", rv, 16'h0000);
    carrier(2, 2); rd(A_RX, rv); check("R8 collision same cycle", rv, 16'h0000);
    carrier(2, 3); rd(A_RX, rv); check("R8 collision after", rv, 16'h0001);
    // R4 saturation of receive-error counter
    for (int j = 0; j < 260; j++) carrier(1, 0);
    rd(A_RX, rv); check("R4 rx sticks", rv, 16'h00FF);
    // R9/R1 writes, upper byte ignored
    wr(A_FC, 16'hAB5C); rd(A_FC, rv); check("R9 R1 fc write", rv, 16'h005C);
    wr(A_RX, 16'hFF07); rd(A_RX, rv); check("R9 R1 rx write", rv, 16'h0007);
    // R10 unmapped addresses and hold
    wr(A_FC, 16'h0033);
    rd(8'hD8, rv); check("R10 unmapped D8", rv, 16'h0000);
    rd(8'h00, rv); check("R10 unmapped 00", rv, 16'h0000);
    rd(A_FC, rv);
    repeat (3) @(negedge clk);
    check("R10 rdata holds", reg_rdata, 16'h0033);
    // R11 event during read
    fc_pulses(5);
    @(negedge clk); fc_event = 1'b1; reg_rd = 1'b1; reg_addr = A_FC;
    @(negedge clk); fc_event = 1'b0; reg_rd = 1'b0; rv = reg_rdata;
    check("R11 old value", rv, 16'h0005);
    rd(A_FC, rv); check("R11 event kept", rv, 16'h0001);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule